// File: doc/BRIEF.md
# Undefined Command Pass-Through Filter

This block sits beside the interface command decoder of a bus device. It sees every received command byte along with the decoder's verdict on it. The decoder supplies the group class of the byte and says whether it recognised the byte. The block then decides whether the host must deal with the byte instead. A byte it hands over is latched into a register the host can read. A flag is raised, and a hold-off output stalls the bus handshake until the host has read the register.

Two kinds of bytes are handed over. The first kind is an unrecognised command. An unrecognised universal command is passed whenever pass-through is enabled. An unrecognised addressed command is passed only while the device is addressed as talker or as listener; otherwise it is dropped. Once a primary command has been passed, every secondary byte after it is passed too. That run ends at the next primary byte that is not passed.

The second kind is a secondary address, which the block flags separately so the host can validate it. This happens only in the addressing mode that needs host validation, and only for a secondary address that follows the device's own primary address. In the other two modes the block leaves secondary addresses alone. In those modes the decoder either recognises them internally or ignores them.

Top module: `cmdpt_filter`

## Requirements
- R1: After synchronous reset, `pt_data` is 0 and `cmd_flag`, `addr_flag` and `hold_bus` are all 0.
- R2: A valid universal command (`cmd_grp` = 2'b00) with `cmd_undef`=1 and `pt_en`=1 is passed. One cycle later `pt_data` equals the byte, `cmd_flag`=1, `addr_flag`=0 and `hold_bus`=1.
- R3: A valid undefined addressed command (`cmd_grp` = 2'b01) with `pt_en`=1 is passed only if `talk_addr` or `listen_addr` is 1. Otherwise `pt_data`, the flags and `hold_bus` are left unchanged.
- R4: A primary command with `cmd_undef`=0 is never passed.
- R5: With `pt_en`=0, no command (primary or secondary) is passed as an undefined command, and no hold-off results from one.
- R6: A valid secondary byte (`cmd_grp` = 2'b10) is passed with `cmd_flag`=1 when the last primary byte was passed and `pt_en`=1. This holds whatever the value of `cmd_undef`.
- R7: When R6 does not apply, a valid secondary byte with `own_prim`=1 and `addr_mode`=2'd3 is latched into `pt_data`, with `addr_flag`=1, `cmd_flag`=0 and `hold_bus`=1. The two flags are never 1 together.
- R8: With `addr_mode` of 2'd1 or 2'd2, a secondary byte that does not follow a passed primary is not passed.
- R9: A cycle with `host_rd`=1 and no pass clears `cmd_flag`, `addr_flag` and `hold_bus` on the next cycle. `pt_data` keeps its value.
- R10: When a pass and `host_rd` occur in the same cycle, the pass wins. The new byte is latched and the matching flag and `hold_bus` stay 1.
- R11: A valid byte of group 2'b11 (other primary, such as an address) is never passed and ends a run of passed secondaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A received byte is presented this cycle |
| cmd_byte | input | CMD_W | Received command byte |
| cmd_grp | input | 2 | Group: 00 universal, 01 addressed, 10 secondary, 11 other primary |
| cmd_undef | input | 1 | Decoder did not recognise the byte |
| talk_addr | input | 1 | Device is addressed as talker |
| listen_addr | input | 1 | Device is addressed as listener |
| pt_en | input | 1 | Pass-through enable |
| addr_mode | input | 2 | Addressing mode 1, 2 or 3 |
| own_prim | input | 1 | Last primary byte was this device's own address |
| host_rd | input | 1 | Host reads the pass-through register |
| pt_data | output | CMD_W | Pass-through register |
| cmd_flag | output | 1 | Undefined-command flag |
| addr_flag | output | 1 | Secondary-address flag |
| hold_bus | output | 1 | Handshake hold-off |

## Verification
The assertions rely on one assumption about the surroundings: while `hold_bus` is 1, no new byte arrives unless the host reads in that same cycle, because the stalled handshake stops the bus. The stimulus meets this by computing the expected `hold_bus` and withholding `cmd_valid` in any cycle where that value is 1 and no read is issued. Under this condition the two flags can never be left set by two overlapping passes, and every pass is followed by a hold-off.

// File: rtl/cmdpt_pkg.sv
package cmdpt_pkg;
  typedef enum logic [1:0] {
    GRP_UNIV  = 2'b00,
    GRP_ADDR  = 2'b01,
    GRP_SEC   = 2'b10,
    GRP_OTHER = 2'b11
  } grp_e;

  localparam logic [1:0] MODE_HOST_CHECK = 2'd3;
endpackage

// File: rtl/cmdpt_qualify.sv
module cmdpt_qualify
  import cmdpt_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] grp,
  input  logic       undef,
  input  logic       talk_act,
  input  logic       listen_act,
  input  logic       enable,
  input  logic [1:0] mode,
  input  logic       own_prim,
  input  logic       chain_q,
  output logic       pass_cmd,
  output logic       pass_addr,
  output logic       primary
);
  grp_e g;
  assign g = grp_e'(grp);

  always_comb begin
    pass_cmd  = 1'b0;
    pass_addr = 1'b0;
    primary   = valid && (g != GRP_SEC);
    if (valid) begin
      unique case (g)
        GRP_UNIV:  pass_cmd = undef && enable;
        GRP_ADDR:  pass_cmd = undef && enable && (talk_act || listen_act);
        GRP_SEC: begin
          if (chain_q && enable)
            pass_cmd = 1'b1;
          else if (own_prim && (mode == MODE_HOST_CHECK))
            pass_addr = 1'b1;
        end
        default:   pass_cmd = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cmdpt_chain.sv
module cmdpt_chain (
  input  logic clk,
  input  logic rst,
  input  logic primary,
  input  logic pass_cmd,
  output logic chain_q
);
  always_ff @(posedge clk) begin
    if (rst)
      chain_q <= 1'b0;
    else if (primary)
      chain_q <= pass_cmd;
  end
endmodule

// File: rtl/cmdpt_hold.sv
module cmdpt_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pass_cmd,
  input  logic         pass_addr,
  input  logic [W-1:0] byte_in,
  input  logic         host_rd,
  output logic [W-1:0] pt_q,
  output logic         cmd_q,
  output logic         addr_q,
  output logic         hold_q
);
  logic take;
  assign take = pass_cmd || pass_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pt_q   <= '0;
      cmd_q  <= 1'b0;
      addr_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (take) begin
      pt_q   <= byte_in;
      cmd_q  <= pass_cmd;
      addr_q <= pass_addr;
      hold_q <= 1'b1;
    end else if (host_rd) begin
      cmd_q  <= 1'b0;
      addr_q <= 1'b0;
      hold_q <= 1'b0;
    end
  end

  AST_PASS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    take |=> hold_q && (pt_q == $past(byte_in))); // R2
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !take) |=> !hold_q && !cmd_q && !addr_q && $stable(pt_q)); // R9
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_q, addr_q})); // R7
endmodule

// File: rtl/cmdpt_filter.sv
module cmdpt_filter
  import cmdpt_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic [1:0]       cmd_grp,
  input  logic             cmd_undef,
  input  logic             talk_addr,
  input  logic             listen_addr,
  input  logic             pt_en,
  input  logic [1:0]       addr_mode,
  input  logic             own_prim,
  input  logic             host_rd,
  output logic [CMD_W-1:0] pt_data,
  output logic             cmd_flag,
  output logic             addr_flag,
  output logic             hold_bus
);
  logic pass_cmd, pass_addr, primary, chain_q;

  cmdpt_qualify u_qual (
    .valid(cmd_valid), .grp(cmd_grp), .undef(cmd_undef),
    .talk_act(talk_addr), .listen_act(listen_addr), .enable(pt_en),
    .mode(addr_mode), .own_prim(own_prim), .chain_q(chain_q),
    .pass_cmd(pass_cmd), .pass_addr(pass_addr), .primary(primary)
  );

  cmdpt_chain u_chain (
    .clk(clk), .rst(rst), .primary(primary), .pass_cmd(pass_cmd),
    .chain_q(chain_q)
  );

  cmdpt_hold #(.W(CMD_W)) u_hold (
    .clk(clk), .rst(rst), .pass_cmd(pass_cmd), .pass_addr(pass_addr),
    .byte_in(cmd_byte), .host_rd(host_rd),
    .pt_q(pt_data), .cmd_q(cmd_flag), .addr_q(addr_flag), .hold_q(hold_bus)
  );

  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (hold_bus && !host_rd) |-> !cmd_valid); // R2
  AST_UNADDR_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_grp == GRP_ADDR && !talk_addr && !listen_addr)
    |=> $stable(pt_data) && !$rose(hold_bus)); // R3
  AST_KNOWN_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_undef && cmd_grp != GRP_SEC)
    |=> $stable(pt_data) && !$rose(hold_bus)); // R4
  AST_OFF_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !pt_en) |=> !$rose(cmd_flag)); // R5
  AST_OTHER_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_grp == GRP_OTHER) |=> $stable(pt_data) && !$rose(hold_bus)); // R11
endmodule

// File: tb/tb_cmdpt_filter.sv
`timescale 1ns/1ps
module tb_cmdpt_filter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid = 1'b0, undef = 1'b0, tk = 1'b0, ln = 1'b0, en = 1'b1, own = 1'b0, rd = 1'b0;
  logic [1:0] grp = 2'b00, mode = 2'd1;
  logic [7:0] byte_i = 8'h00;
  logic [7:0] pt_data;
  logic cmd_flag, addr_flag, hold_bus;

  int compared = 0, mismatched = 0;
  int cycles = 0;
  logic [7:0] m_reg = 8'h00;
  bit m_cmd = 0, m_addr = 0, m_hold = 0, m_chain = 0;

  always #2.5 clk = ~clk;

  cmdpt_filter #(.CMD_W(8)) dut (
    .clk(clk), .rst(rst), .cmd_valid(valid), .cmd_byte(byte_i), .cmd_grp(grp),
    .cmd_undef(undef), .talk_addr(tk), .listen_addr(ln), .pt_en(en),
    .addr_mode(mode), .own_prim(own), .host_rd(rd),
    .pt_data(pt_data), .cmd_flag(cmd_flag), .addr_flag(addr_flag), .hold_bus(hold_bus)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cyc(input string tag);
    bit pc, pa;
    pc = 0; pa = 0;
    if (rst) begin
      m_reg = 8'h00; m_cmd = 0; m_addr = 0; m_hold = 0; m_chain = 0;
    end else begin
      if (valid) begin
        if (grp == 2'b00) pc = undef && en;
        else if (grp == 2'b01) pc = undef && en && (tk || ln);
        else if (grp == 2'b10) begin
          if (m_chain && en) pc = 1;
          else if (own && mode == 2'd3) pa = 1;
        end
        if (grp != 2'b10) m_chain = pc;
      end
      if (pc || pa) begin
        m_reg = byte_i; m_cmd = pc; m_addr = pa; m_hold = 1;
      end else if (rd) begin
        m_cmd = 0; m_addr = 0; m_hold = 0;
      end
    end
    @(posedge clk);
    #1;
    compared++;
    if (pt_data !== m_reg || cmd_flag !== m_cmd || addr_flag !== m_addr || hold_bus !== m_hold) begin
      mismatched++;
      $display("FAIL %s: actual reg=%h cmd=%b addr=%b hold=%b expected reg=%h cmd=%b addr=%b hold=%b",
               tag, pt_data, cmd_flag, addr_flag, hold_bus, m_reg, m_cmd, m_addr, m_hold);
    end
    valid = 0; rd = 0;
  endtask

  task automatic send(input logic [1:0] g, input logic u, input logic [7:0] b, input string tag);
    valid = 1; grp = g; undef = u; byte_i = b;
    cyc(tag);
  endtask

  task automatic read(input string tag);
    rd = 1;
    cyc(tag);
  endtask

  initial begin
    repeat (3) cyc("R1");
    rst = 0;
    cyc("R1");
    // R2: universal undefined passes, then R9 read releases
    send(2'b00, 1, 8'h15, "R2");
    cyc("R2");
    read("R9");
    cyc("R9");
    // R3: addressed undefined needs addressed state
    send(2'b01, 1, 8'h22, "R3");
    tk = 1; send(2'b01, 1, 8'h23, "R3"); read("R3"); tk = 0;
    ln = 1; send(2'b01, 1, 8'h24, "R3"); read("R3"); ln = 0;
    // R4: defined commands dropped
    send(2'b00, 0, 8'h31, "R4");
    tk = 1; send(2'b01, 0, 8'h32, "R4"); tk = 0;
    // R5: disabled
    en = 0; send(2'b00, 1, 8'h41, "R5");
    tk = 1; send(2'b01, 1, 8'h42, "R5"); tk = 0; en = 1;
    // R6: chain of secondaries, R11 ends it
    send(2'b00, 1, 8'h51, "R6"); read("R6");
    send(2'b10, 0, 8'h61, "R6"); read("R6");
    send(2'b10, 1, 8'h62, "R6"); read("R6");
    send(2'b11, 1, 8'h20, "R11");
    send(2'b10, 1, 8'h63, "R11");
    // R7 / R8: secondary address handling by mode
    own = 1; mode = 2'd3; send(2'b10, 0, 8'h70, "R7"); read("R7");
    mode = 2'd2; send(2'b10, 0, 8'h71, "R8");
    mode = 2'd1; send(2'b10, 0, 8'h72, "R8"); own = 0;
    // R10: pass and read together
    send(2'b00, 1, 8'h81, "R10");
    rd = 1; send(2'b00, 1, 8'h82, "R10");
    read("R10");
    // mixed stimulus, assumption kept: no byte while held without a read
    for (int i = 0; i < 600; i++) begin
      rd = ($urandom % 3) == 0;
      valid = ($urandom % 2) == 0;
      if (m_hold && !rd) valid = 0;
      grp = 2'($urandom); undef = 1'($urandom); tk = 1'($urandom); ln = 1'($urandom);
      en = ($urandom % 5) != 0; own = 1'($urandom);
      mode = 2'(1 + ($urandom % 3)); byte_i = 8'($urandom);
      cyc("R6");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule